// File: doc/BRIEF.md
# Decode Stage Skid-Buffer Controller

This block sits between an instruction fetch stage and a rename stage and handles the flow of one thread through decode. Each cycle it receives a group of up to `FETCH_W` opaque instruction records from fetch. Each record carries a tag, a "killed" mark and a "no source operands" mark. It forwards at most `DEC_W` of them to rename one cycle later. Killed records are consumed without taking an output slot. A forwarded record with no source operands goes out with its ready-to-issue bit set.

The stage keeps one sticky stall flag for each downstream source: rename, execute and commit. Each flag is set by that source's stall pulse and cleared by its resume pulse. A five-state controller moves between Idle, Running, Blocked, Unblocking and Squashing. While stalled, or when more records arrive than the width allows, records are parked in a skid buffer of depth `FETCH_LAT*FETCH_W + DEC_W`. Fetch is told to hold off with a single block pulse. Once the stalls clear, the buffer drains oldest-first, and new arrivals queue behind it. When the buffer is empty, fetch receives an unblock pulse. A squash from commit throws away everything pending.

Top module: `decode_skid_stage`

## Requirements
- R1: After reset, `stageState` is 0 (Idle), `renameCount`, `fetchBlock`, `fetchUnblock`, `protoErr` and `skidOverflow` are 0, all stall flags are clear and the skid buffer is empty.
- R2: All outputs are registered: the effect of the inputs sampled at one rising edge is visible after that edge. `renameCount` never exceeds `DEC_W`. Forwarded records occupy slots 0 upward of `renameTags` (slot j at bits j*TAG_W and up), oldest first. State codes are Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.
- R3: Slot j of `renameReady` equals the no-source mark of the record in slot j.
- R4: In Idle or Running, records are taken from the fetch group in order. A killed record is consumed without a slot until `DEC_W` live records have gone out. Any records left unconsumed move to the skid buffer, the state becomes Blocked and `fetchBlock` pulses.
- R5: A stall pulse sets that source's flag and a resume pulse clears it. While any flag is set after applying the pulses of the current cycle, the stage forwards nothing, parks the whole fetch group in the skid buffer and moves to Blocked.
- R6: `fetchBlock` pulses only on a move to Blocked from a state other than Blocked.
- R7: When Blocked with no stall and a non-empty skid buffer, the stage enters Unblocking. In Unblocking it forwards from the skid buffer head under the R4 slot rules, and appends each new fetch group behind the remaining entries.
- R8: When the skid buffer becomes empty in Unblocking, or when Blocked with no stall and an empty buffer, `fetchUnblock` pulses and the state becomes Running. In the second case the current fetch group is processed as in Running.
- R9: A commit squash or a commit squash-hold, checked ahead of any stall, moves the state to Squashing. It empties the skid buffer, discards the fetch group and forwards nothing. `fetchUnblock` pulses if the state was Blocked or Unblocking.
- R10: Squashing with no squash, no hold and no stall returns to Running and processes that cycle's fetch group.
- R11: A resume pulse for a source whose flag is clear, with no stall pulse for that source in the same cycle, sets the sticky `protoErr`.
- R12: A push beyond the skid buffer depth drops the excess records (the youngest) and sets the sticky `skidOverflow`.
- R13: In Idle the fetch group is forwarded as in Running, and the state stays Idle unless a transition above applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchCount | input | $clog2(FETCH_W+1) | Number of valid records in the fetch group |
| fetchTags | input | FETCH_W*TAG_W | Record tags, record i at bits i*TAG_W |
| fetchKilled | input | FETCH_W | Killed mark for each record |
| fetchNoSrc | input | FETCH_W | No-source-operand mark for each record |
| renameStall | input | 1 | Stall pulse from rename |
| renameResume | input | 1 | Resume pulse from rename |
| execStall | input | 1 | Stall pulse from execute |
| execResume | input | 1 | Resume pulse from execute |
| commitStall | input | 1 | Stall pulse from commit |
| commitResume | input | 1 | Resume pulse from commit |
| commitSquash | input | 1 | Squash request from commit |
| commitSquashHold | input | 1 | Commit still squashing |
| renameCount | output | $clog2(DEC_W+1) | Number of records forwarded |
| renameTags | output | DEC_W*TAG_W | Forwarded tags |
| renameReady | output | DEC_W | Ready-to-issue bit for each slot |
| fetchBlock | output | 1 | Block pulse to fetch |
| fetchUnblock | output | 1 | Unblock pulse to fetch |
| stageState | output | 3 | Current controller state |
| protoErr | output | 1 | Sticky protocol error |
| skidOverflow | output | 1 | Sticky skid overflow |

## Verification
The forwarding rule is swept over every group size from 0 to 4 combined with all 16 killed masks, starting from Running. This tells apart slot counting of live records from counting of consumed records. It also shows when a leftover forces a block, including killed records stranded behind a full width. Directed sequences check three further behaviours. A stall while records keep arriving shows that draining is oldest-first and that unblock is signalled only when the buffer is empty. Overlapping stalls from two sources show that the flags are independent, and a squash during Blocked shows that parked records are truly discarded. A fill past the depth shows that only the youngest records are lost, and an unpaired resume raises the error flag.

// File: rtl/decode_skid_pkg.sv
package decode_skid_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4
  } stage_state_e;

  // Per-cycle strobes from control to datapath; exactly one is high.
  typedef struct packed {
    logic flush;  // drop skid contents and the fetch group
    logic park;   // append the whole fetch group to the skid
    logic pass;   // forward from the fetch group, park leftovers
    logic drain;  // forward from skid head, append the fetch group
  } ctl_strobe_t;

endpackage

// File: rtl/decode_skid_ctrl.sv
module decode_skid_ctrl
  import decode_skid_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   stallP,
  input  logic [2:0]   resumeP,
  input  logic         squash,
  input  logic         squashHold,
  input  logic         skidEmpty,
  input  logic         skidEmptyNext,
  input  logic         inLeft,
  output ctl_strobe_t  ctl,
  output stage_state_e state,
  output logic         fetchBlock,
  output logic         fetchUnblock,
  output logic         protoErr
);

  logic [2:0]   stallQ;
  logic [2:0]   stallNext;
  logic         stalled;
  stage_state_e effState;
  stage_state_e nState;
  logic         unbFromBlk;
  logic         blkPulse;
  logic         unbPulse;
  logic         errNow;

  // Mode choice: depends only on registered state and this cycle's inputs.
  always_comb begin : modeSel
    stallNext  = (stallQ | stallP) & ~resumeP;
    stalled    = |stallNext;
    ctl        = '0;
    effState   = state;
    unbFromBlk = 1'b0;
    if (squash || squashHold) begin
      ctl.flush = 1'b1;
    end else if (stalled) begin
      ctl.park = 1'b1;
    end else begin
      if (state == ST_BLK) begin
        if (skidEmpty) begin
          effState   = ST_RUN;
          unbFromBlk = 1'b1;
        end else begin
          effState = ST_UNB;
        end
      end else if (state == ST_SQ) begin
        effState = ST_RUN;
      end
      if (effState == ST_UNB) ctl.drain = 1'b1;
      else                    ctl.pass  = 1'b1;
    end
  end

  // Next state and pulses: uses the datapath's view of the skid after this cycle.
  always_comb begin : nextSel
    nState   = state;
    blkPulse = 1'b0;
    unbPulse = 1'b0;
    if (ctl.flush) begin
      nState   = ST_SQ;
      unbPulse = (state == ST_BLK) || (state == ST_UNB);
    end else if (ctl.park) begin
      nState   = ST_BLK;
      blkPulse = (state != ST_BLK);
    end else if (ctl.drain) begin
      if (skidEmptyNext) begin
        nState   = ST_RUN;
        unbPulse = 1'b1;
      end else begin
        nState = ST_UNB;
      end
    end else begin
      nState   = effState;
      unbPulse = unbFromBlk;
      if (inLeft) begin
        nState   = ST_BLK;
        blkPulse = (state != ST_BLK);
        unbPulse = 1'b0;
      end
    end
  end

  assign errNow = |(resumeP & ~stallQ & ~stallP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      stallQ       <= '0;
      fetchBlock   <= 1'b0;
      fetchUnblock <= 1'b0;
      protoErr     <= 1'b0;
    end else begin
      state        <= nState;
      stallQ       <= stallNext;
      fetchBlock   <= blkPulse;
      fetchUnblock <= unbPulse;
      protoErr     <= protoErr | errNow;
    end
  end

endmodule

// File: rtl/decode_skid_dp.sv
module decode_skid_dp
  import decode_skid_pkg::*;
#(
  parameter int FETCH_W    = 4,
  parameter int DEC_W      = 2,
  parameter int SKID_DEPTH = 6,
  parameter int TAG_W      = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctl_strobe_t                ctl,
  input  logic [$clog2(FETCH_W+1)-1:0] inCount,
  input  logic [FETCH_W*TAG_W-1:0]   inTags,
  input  logic [FETCH_W-1:0]         inKill,
  input  logic [FETCH_W-1:0]         inNoSrc,
  output logic [$clog2(DEC_W+1)-1:0] outCount,
  output logic [DEC_W*TAG_W-1:0]     outTags,
  output logic [DEC_W-1:0]           outReady,
  output logic                       skidEmpty,
  output logic                       skidEmptyNext,
  output logic                       inLeft,
  output logic                       overflow
);

  localparam int OCW = $clog2(DEC_W + 1);
  localparam int CW  = $clog2(SKID_DEPTH + 1);
  localparam int PW  = (SKID_DEPTH > 1) ? $clog2(SKID_DEPTH) : 1;
  localparam int SL  = (SKID_DEPTH > FETCH_W) ? SKID_DEPTH : FETCH_W;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             kill;
    logic             noSrc;
  } ent_t;

  ent_t          memEnt [SKID_DEPTH];
  ent_t          inEnt  [FETCH_W];
  ent_t          vEnt   [SL];
  logic [PW-1:0] head;
  logic [CW-1:0] cnt;

  logic [TAG_W-1:0] slotTag [DEC_W];
  logic [DEC_W-1:0] slotRdy;
  int inAvail, availN, scanUsed, scanLive;
  int pushN, pushBase, popN, keptN, acceptN, headAfter, roomN;
  logic ovfNow;

  function automatic int wrapIdx(input int v);
    return v % SKID_DEPTH;
  endfunction

  genvar g;
  generate
    for (g = 0; g < FETCH_W; g++) begin : gIn
      assign inEnt[g] = '{tag: inTags[g*TAG_W +: TAG_W], kill: inKill[g], noSrc: inNoSrc[g]};
    end
    for (g = 0; g < SL; g++) begin : gView
      ent_t fromSkid;
      ent_t fromIn;
      if (g < FETCH_W) begin : gHasIn
        assign fromIn = inEnt[g];
      end else begin : gNoIn
        assign fromIn = '0;
      end
      assign fromSkid = memEnt[PW'(wrapIdx(int'(head) + g))];
      assign vEnt[g]  = ctl.drain ? fromSkid : fromIn;
    end
  endgenerate

  assign skidEmpty = (cnt == '0);

  // Slot assignment over the selected source.
  always_comb begin : scanBlk
    inAvail  = (int'(inCount) > FETCH_W) ? FETCH_W : int'(inCount);
    availN   = ctl.drain ? int'(cnt) : inAvail;
    scanUsed = 0;
    scanLive = 0;
    slotRdy  = '0;
    for (int j = 0; j < DEC_W; j++) slotTag[j] = '0;
    for (int i = 0; i < SL; i++) begin
      if (i < availN && scanLive < DEC_W) begin
        scanUsed = i + 1;
        if (!vEnt[i].kill) begin
          slotTag[scanLive] = vEnt[i].tag;
          slotRdy[scanLive] = vEnt[i].noSrc;
          scanLive          = scanLive + 1;
        end
      end
    end
  end

  // Skid bookkeeping for this cycle.
  always_comb begin : pushBlk
    pushN    = 0;
    pushBase = 0;
    if (ctl.park || ctl.drain) begin
      pushN = inAvail;
    end else if (ctl.pass) begin
      pushBase = scanUsed;
      pushN    = inAvail - scanUsed;
    end
    popN          = ctl.drain ? scanUsed : 0;
    keptN         = int'(cnt) - popN;
    headAfter     = wrapIdx(int'(head) + popN);
    roomN         = SKID_DEPTH - keptN;
    acceptN       = (pushN > roomN) ? roomN : pushN;
    ovfNow        = !ctl.flush && (pushN > roomN);
    skidEmptyNext = ((keptN + acceptN) == 0);
    inLeft        = ctl.pass && (pushN > 0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head     <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
      outCount <= '0;
      outTags  <= '0;
      outReady <= '0;
    end else begin
      if (ctl.flush) begin
        head <= '0;
        cnt  <= '0;
      end else begin
        head <= PW'(headAfter);
        cnt  <= CW'(keptN + acceptN);
      end
      overflow <= overflow | ovfNow;
      if (ctl.pass || ctl.drain) begin
        outCount <= OCW'(scanLive);
        outReady <= slotRdy;
        for (int j = 0; j < DEC_W; j++) outTags[j*TAG_W +: TAG_W] <= slotTag[j];
      end else begin
        outCount <= '0;
        outReady <= '0;
        outTags  <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!ctl.flush) begin
      for (int k = 0; k < FETCH_W; k++) begin
        if (k < acceptN && (pushBase + k) < FETCH_W) begin
          memEnt[PW'(wrapIdx(headAfter + keptN + k))] <= inEnt[pushBase + k];
        end
      end
    end
  end

endmodule

// File: rtl/decode_skid_stage.sv
module decode_skid_stage
  import decode_skid_pkg::*;
#(
  parameter int FETCH_W   = 4,
  parameter int DEC_W     = 2,
  parameter int FETCH_LAT = 1,
  parameter int TAG_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(FETCH_W+1)-1:0] fetchCount,
  input  logic [FETCH_W*TAG_W-1:0]     fetchTags,
  input  logic [FETCH_W-1:0]           fetchKilled,
  input  logic [FETCH_W-1:0]           fetchNoSrc,
  input  logic                         renameStall,
  input  logic                         renameResume,
  input  logic                         execStall,
  input  logic                         execResume,
  input  logic                         commitStall,
  input  logic                         commitResume,
  input  logic                         commitSquash,
  input  logic                         commitSquashHold,
  output logic [$clog2(DEC_W+1)-1:0]   renameCount,
  output logic [DEC_W*TAG_W-1:0]       renameTags,
  output logic [DEC_W-1:0]             renameReady,
  output logic                         fetchBlock,
  output logic                         fetchUnblock,
  output logic [2:0]                   stageState,
  output logic                         protoErr,
  output logic                         skidOverflow
);

  localparam int SKID_DEPTH = FETCH_LAT * FETCH_W + DEC_W;

  ctl_strobe_t  ctl;
  stage_state_e state;
  logic         skidEmpty;
  logic         skidEmptyNext;
  logic         inLeft;

  decode_skid_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .stallP       ({commitStall, execStall, renameStall}),
    .resumeP      ({commitResume, execResume, renameResume}),
    .squash       (commitSquash),
    .squashHold   (commitSquashHold),
    .skidEmpty    (skidEmpty),
    .skidEmptyNext(skidEmptyNext),
    .inLeft       (inLeft),
    .ctl          (ctl),
    .state        (state),
    .fetchBlock   (fetchBlock),
    .fetchUnblock (fetchUnblock),
    .protoErr     (protoErr)
  );

  decode_skid_dp #(
    .FETCH_W   (FETCH_W),
    .DEC_W     (DEC_W),
    .SKID_DEPTH(SKID_DEPTH),
    .TAG_W     (TAG_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .inCount      (fetchCount),
    .inTags       (fetchTags),
    .inKill       (fetchKilled),
    .inNoSrc      (fetchNoSrc),
    .outCount     (renameCount),
    .outTags      (renameTags),
    .outReady     (renameReady),
    .skidEmpty    (skidEmpty),
    .skidEmptyNext(skidEmptyNext),
    .inLeft       (inLeft),
    .overflow     (skidOverflow)
  );

  assign stageState = state;

endmodule

// File: rtl/decode_skid_chk.sv
module decode_skid_chk #(
  parameter int DEC_W = 2
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [$clog2(DEC_W+1)-1:0] renameCount,
  input logic                       fetchBlock,
  input logic                       fetchUnblock,
  input logic [2:0]                 stageState,
  input logic                       protoErr,
  input logic                       skidOverflow
);

  // R2
  count_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(renameCount) <= DEC_W);

  // R2
  state_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageState <= 3'd4);

  // R4
  block_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchBlock |-> stageState == 3'd2);

  // R6
  block_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchBlock |-> $past(stageState) != 3'd2);

  // R8
  unblock_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchUnblock |-> (stageState == 3'd1 || stageState == 3'd4));

  // R9
  squash_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageState == 3'd4 |-> renameCount == '0);

  // R11
  proto_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R12
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    skidOverflow |=> skidOverflow);

endmodule

bind decode_skid_stage decode_skid_chk #(.DEC_W(DEC_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .renameCount (renameCount),
  .fetchBlock  (fetchBlock),
  .fetchUnblock(fetchUnblock),
  .stageState  (stageState),
  .protoErr    (protoErr),
  .skidOverflow(skidOverflow)
);

// File: tb/sim_decode_skid_stage.sv
`timescale 1ns/1ps
module sim_decode_skid_stage;

  localparam int FW = 4;
  localparam int DW = 2;
  localparam int TW = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [2:0]      fetchCount;
  logic [FW*TW-1:0] fetchTags;
  logic [FW-1:0]   fetchKilled, fetchNoSrc;
  logic renameStall, renameResume, execStall, execResume, commitStall, commitResume;
  logic commitSquash, commitSquashHold;
  logic [1:0]      renameCount;
  logic [DW*TW-1:0] renameTags;
  logic [DW-1:0]   renameReady;
  logic fetchBlock, fetchUnblock, protoErr, skidOverflow;
  logic [2:0]      stageState;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  decode_skid_stage #(.FETCH_W(FW), .DEC_W(DW), .FETCH_LAT(1), .TAG_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .fetchCount(fetchCount), .fetchTags(fetchTags),
    .fetchKilled(fetchKilled), .fetchNoSrc(fetchNoSrc),
    .renameStall(renameStall), .renameResume(renameResume),
    .execStall(execStall), .execResume(execResume),
    .commitStall(commitStall), .commitResume(commitResume),
    .commitSquash(commitSquash), .commitSquashHold(commitSquashHold),
    .renameCount(renameCount), .renameTags(renameTags), .renameReady(renameReady),
    .fetchBlock(fetchBlock), .fetchUnblock(fetchUnblock), .stageState(stageState),
    .protoErr(protoErr), .skidOverflow(skidOverflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearIn();
    fetchCount = '0; fetchTags = '0; fetchKilled = '0; fetchNoSrc = '0;
    renameStall = 0; renameResume = 0; execStall = 0; execResume = 0;
    commitStall = 0; commitResume = 0; commitSquash = 0; commitSquashHold = 0;
  endtask

  task automatic grp(input int n, input int base, input int killM, input int nsM);
    fetchCount = 3'(n);
    for (int i = 0; i < FW; i++) fetchTags[i*TW +: TW] = TW'(base + i);
    fetchKilled = 4'(killM);
    fetchNoSrc  = 4'(nsM);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int oTag(input int j);
    return int'(renameTags[j*TW +: TW]);
  endfunction

  task automatic doReset();
    rstN = 0;
    clearIn();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic toRunning();
    clearIn(); commitSquash = 1; tick();
    clearIn(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset values
    chk("R1 state", stageState, 0);
    chk("R1 count", renameCount, 0);
    chk("R1 block", fetchBlock, 0);
    chk("R1 unblock", fetchUnblock, 0);
    chk("R1 protoErr", protoErr, 0);
    chk("R1 overflow", skidOverflow, 0);

    // R13 Idle forwards without leaving Idle
    grp(2, 5, 0, 2); tick(); clearIn();
    chk("R13 count", renameCount, 2);
    chk("R13 tag0", oTag(0), 5);
    chk("R13 tag1", oTag(1), 6);
    chk("R3 ready", renameReady, 2);
    chk("R13 state", stageState, 0);

    // R2 R3 R4 sweep over group size and killed mask
    for (int n = 0; n <= FW; n++) begin
      for (int km = 0; km < 16; km++) begin
        int ns, live, used;
        int eT[DW];
        int eR[DW];
        toRunning();
        chk("R10 running", stageState, 1);
        ns = (km * 5 + 3) & 15;
        grp(n, 16, km, ns); tick(); clearIn();
        live = 0; used = 0;
        for (int j = 0; j < DW; j++) begin eT[j] = 0; eR[j] = 0; end
        for (int i = 0; i < n; i++) begin
          if (live < DW) begin
            used = i + 1;
            if (((km >> i) & 1) == 0) begin
              eT[live] = 16 + i;
              eR[live] = (ns >> i) & 1;
              live++;
            end
          end
        end
        chk("R2 count", renameCount, live);
        for (int j = 0; j < live; j++) begin
          chk("R2 tag", oTag(j), eT[j]);
          chk("R3 ready", int'(renameReady[j]), eR[j]);
        end
        chk("R4 state", stageState, (n > used) ? 2 : 1);
        chk("R4 block", fetchBlock, (n > used) ? 1 : 0);
      end
    end

    // R5 R6 R7 R8 stall, park, drain in order
    toRunning();
    renameStall = 1; grp(3, 32, 0, 0); tick(); clearIn();
    chk("R5 state", stageState, 2);
    chk("R5 count", renameCount, 0);
    chk("R6 first block", fetchBlock, 1);
    grp(1, 35, 0, 0); tick(); clearIn();
    chk("R5 still blocked", stageState, 2);
    chk("R6 no repeat block", fetchBlock, 0);
    renameResume = 1; grp(2, 36, 0, 0); tick(); clearIn();
    chk("R7 state", stageState, 3);
    chk("R7 count", renameCount, 2);
    chk("R7 tag0", oTag(0), 32);
    chk("R7 tag1", oTag(1), 33);
    chk("R8 no early unblock", fetchUnblock, 0);
    tick();
    chk("R7 tag0b", oTag(0), 34);
    chk("R7 tag1b", oTag(1), 35);
    chk("R7 stays", stageState, 3);
    tick();
    chk("R7 tag0c", oTag(0), 36);
    chk("R7 tag1c", oTag(1), 37);
    chk("R8 running", stageState, 1);
    chk("R8 unblock", fetchUnblock, 1);
    chk("R11 clean", protoErr, 0);

    // R5 independent flags, R8 empty-skid release
    renameStall = 1; execStall = 1; tick(); clearIn();
    chk("R5 two stalls", stageState, 2);
    renameResume = 1; tick(); clearIn();
    chk("R5 exec holds", stageState, 2);
    chk("R6 no block", fetchBlock, 0);
    execResume = 1; tick(); clearIn();
    chk("R8 empty release", stageState, 1);
    chk("R8 empty unblock", fetchUnblock, 1);
    commitStall = 1; tick(); clearIn();
    chk("R5 commit stall", stageState, 2);
    commitResume = 1; grp(1, 50, 0, 1); tick(); clearIn();
    chk("R8 pass after release", renameCount, 1);
    chk("R8 pass tag", oTag(0), 50);
    chk("R8 release state", stageState, 1);
    chk("R8 release pulse", fetchUnblock, 1);
    chk("R11 still clean", protoErr, 0);

    // R9 R10 squash while Blocked discards parked records
    execStall = 1; grp(4, 60, 0, 0); tick(); clearIn();
    chk("R9 pre state", stageState, 2);
    commitSquash = 1; execResume = 1; grp(2, 70, 0, 0); tick(); clearIn();
    chk("R9 state", stageState, 4);
    chk("R9 count", renameCount, 0);
    chk("R9 unblock", fetchUnblock, 1);
    tick();
    chk("R10 state", stageState, 1);
    chk("R10 count", renameCount, 0);
    grp(1, 80, 0, 0); tick(); clearIn();
    chk("R9 skid emptied", oTag(0), 80);
    chk("R9 skid emptied count", renameCount, 1);

    // R9 hold takes priority over a stall
    commitSquashHold = 1; execStall = 1; grp(2, 90, 0, 0); tick(); clearIn();
    chk("R9 hold state", stageState, 4);
    chk("R9 hold no block", fetchBlock, 0);
    chk("R9 hold count", renameCount, 0);
    tick();
    chk("R5 stall after hold", stageState, 2);
    chk("R6 block after hold", fetchBlock, 1);
    execResume = 1; tick(); clearIn();
    chk("R8 back to run", stageState, 1);

    // R11 unpaired resume
    commitResume = 1; tick(); clearIn();
    chk("R11 set", protoErr, 1);
    tick();
    chk("R11 sticky", protoErr, 1);

    // R12 overflow keeps the oldest records
    doReset();
    renameStall = 1; grp(4, 100, 0, 0); tick(); clearIn();
    chk("R12 no ovf yet", skidOverflow, 0);
    grp(4, 104, 0, 0); tick(); clearIn();
    chk("R12 ovf", skidOverflow, 1);
    renameResume = 1; tick(); clearIn();
    chk("R12 tag0", oTag(0), 100);
    chk("R12 tag1", oTag(1), 101);
    tick();
    chk("R12 tag2", oTag(0), 102);
    chk("R12 tag3", oTag(1), 103);
    tick();
    chk("R12 tag4", oTag(0), 104);
    chk("R12 tag5", oTag(1), 105);
    chk("R12 run", stageState, 1);
    tick();
    chk("R12 dropped", renameCount, 0);
    chk("R12 sticky", skidOverflow, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule